// File: doc/BRIEF.md
# Transmit Bit Stuffer for a Dominant/Recessive Serial Bus

This block sits between a frame serializer and the bus driver. It takes frame bits one at a time from an upstream source through a valid/ready handshake and hands them to the line, one bit for each pulse of a bit-time strobe. It watches the levels it has already put on the line. Once five equal levels have gone out, it spends the next strobe on one bit of the opposite level, and it holds off the source for that strobe. The inserted bit is the first bit of a new run, so it can take part in a later insertion.

Logic 0 is the dominant level and logic 1 the recessive level. The line rests recessive after reset. A stuffing enable lets fixed-form fields pass through untouched. A frame start pulse forgets the run history, so a new frame begins with no carried-over run. The run limit, the idle level and whether the output is registered are all parameters.

Top module: `tx_bit_stuffer`

## Requirements
- R1: While stuffing is enabled, no more than five consecutive equal levels appear on the emitted stream of one frame.
- R2: After five equal levels have been emitted, the next strobe emits one bit of the opposite level before any further data bit. This happens even when the next data bit already has the opposite level (0111110 goes out as 01111100, 0111111 as 01111101), and even when the source has no data ready.
- R3: On a strobe that carries a stuff bit, in_ready is low and no data bit is consumed.
- R4: At most one bit is emitted per strobe. tx_emit pulses for one cycle, in the cycle after the strobe, and tx_bit holds its value between emissions. A strobe with no data offered and no stuff due emits nothing, and in_ready is high only during a strobe.
- R5: After reset, tx_bit is 1 (recessive; 0 is dominant), tx_emit is 0 and in_ready is 0.
- R6: A stuff bit starts a new run of length one at its own level, so data 0000011110 goes out as 000001111100.
- R7: With stuff_en low, data bits go out unchanged, no stuff bit is inserted, and in_ready is high on every strobe.
- R8: A frame_start pulse clears the run history. Data 0000 sent before a frame_start, followed by 0000 after it, goes out with no stuff bit.
- R9: A frame of N data bits with stuffing enabled gains at most floor((N-1)/4) stuff bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Bit-time strobe, one cycle per bit slot |
| stuff_en | input | 1 | 1 inserts stuff bits, 0 passes bits through |
| frame_start | input | 1 | Clears the run history; applies before a strobe in the same cycle |
| in_valid | input | 1 | Source offers a data bit |
| in_bit | input | 1 | Offered data bit (0 dominant, 1 recessive) |
| in_ready | output | 1 | Data bit is taken in this cycle when in_valid is also high |
| tx_bit | output | 1 | Line level, held between emissions |
| tx_emit | output | 1 | One-cycle pulse marking a newly emitted bit |

## Verification
The assertions assume that bit_tick is a single-cycle pulse, that in_valid and in_bit are stable across the strobe cycle, and that frame_start is given between frames rather than in the middle of one. The bench drives strobes every second cycle, raises frame_start only in a cycle without a strobe and before each frame, and holds its data steady from the falling edge before a strobe until the one after it. Random frames use runs that are biased toward repeats, so that both the stuffing and the chained-stuff cases come up often.

// File: rtl/stuff_pkg.sv
package stuff_pkg;

   typedef enum logic [1:0] {
      EMIT_NONE  = 2'd0,
      EMIT_DATA  = 2'd1,
      EMIT_STUFF = 2'd2
   } emit_kind_t;

   function automatic int run_cnt_width(input int run_len);
      return $clog2(run_len + 1);
   endfunction

endpackage

// File: rtl/stuff_run_tracker.sv
module stuff_run_tracker
   import stuff_pkg::*;
#(
   parameter int   RUN_LEN    = 5,
   parameter logic IDLE_LEVEL = 1'b1,
   localparam int  CNT_W      = run_cnt_width(RUN_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             emit,
   input  logic             emit_bit,
   output logic [CNT_W-1:0] cur_cnt,
   output logic             cur_lvl
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] run_q, run_d;
   logic             lvl_q, lvl_d;

   // frame_start takes effect before any bit emitted in the same cycle
   always_comb begin
      cur_cnt = frame_start ? '0 : run_q;
      cur_lvl = frame_start ? IDLE_LEVEL : lvl_q;
   end

   always_comb begin
      run_d = cur_cnt;
      lvl_d = cur_lvl;
      if (emit) begin
         lvl_d = emit_bit;
         if (cur_cnt != '0 && emit_bit == cur_lvl)
            run_d = (cur_cnt == CNT_MAX) ? CNT_MAX : cur_cnt + CNT_ONE;
         else
            run_d = CNT_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         lvl_q <= IDLE_LEVEL;
      end else begin
         run_q <= run_d;
         lvl_q <= lvl_d;
      end
   end

   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= CNT_MAX); // R1
   AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (emit && (frame_start || emit_bit != lvl_q)) |=> run_q == CNT_ONE); // R6
   AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !emit) |=> run_q == '0); // R8

endmodule

// File: rtl/stuff_decider.sv
module stuff_decider
   import stuff_pkg::*;
#(
   parameter int  RUN_LEN = 5,
   localparam int CNT_W   = run_cnt_width(RUN_LEN)
) (
   input  logic             bit_tick,
   input  logic             stuff_en,
   input  logic             in_valid,
   input  logic             in_bit,
   input  logic [CNT_W-1:0] cur_cnt,
   input  logic             cur_lvl,
   output logic             in_ready,
   output emit_kind_t       kind,
   output logic             out_bit
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

   logic stuff_due;

   always_comb begin
      stuff_due = stuff_en && (cur_cnt == CNT_MAX);
      in_ready  = bit_tick && !stuff_due;
      kind      = EMIT_NONE;
      out_bit   = in_bit;
      if (bit_tick && stuff_due) begin
         kind    = EMIT_STUFF;
         out_bit = ~cur_lvl;
      end else if (in_ready && in_valid) begin
         kind    = EMIT_DATA;
      end
   end

endmodule

// File: rtl/stuff_out_stage.sv
module stuff_out_stage #(
   parameter bit   OUT_REG    = 1'b1,
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic emit,
   input  logic emit_bit,
   output logic tx_bit,
   output logic tx_emit
);

   generate
      if (OUT_REG) begin : g_reg
         logic bit_q, emit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bit_q  <= IDLE_LEVEL;
               emit_q <= 1'b0;
            end else begin
               emit_q <= emit;
               if (emit) bit_q <= emit_bit;
            end
         end
         assign tx_bit  = bit_q;
         assign tx_emit = emit_q;
      end else begin : g_comb
         logic held_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    held_q <= IDLE_LEVEL;
            else if (emit) held_q <= emit_bit;
         end
         assign tx_bit  = emit ? emit_bit : held_q;
         assign tx_emit = emit;
      end
   endgenerate

endmodule

// File: rtl/tx_bit_stuffer.sv
module tx_bit_stuffer
   import stuff_pkg::*;
#(
   parameter int   RUN_LEN    = 5,
   parameter bit   OUT_REG    = 1'b1,
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic stuff_en,
   input  logic frame_start,
   input  logic in_valid,
   input  logic in_bit,
   output logic in_ready,
   output logic tx_bit,
   output logic tx_emit
);

   localparam int CNT_W = run_cnt_width(RUN_LEN);

   generate
      if (RUN_LEN < 2 || RUN_LEN > 64) begin : g_bad_run_len
         $error("tx_bit_stuffer: RUN_LEN must lie in 2..64");
      end
   endgenerate

   logic [CNT_W-1:0] cur_cnt;
   logic             cur_lvl;
   emit_kind_t       kind;
   logic             out_bit;
   logic             emit;

   assign emit = (kind != EMIT_NONE);

   stuff_run_tracker #(
      .RUN_LEN    (RUN_LEN),
      .IDLE_LEVEL (IDLE_LEVEL)
   ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .emit        (emit),
      .emit_bit    (out_bit),
      .cur_cnt     (cur_cnt),
      .cur_lvl     (cur_lvl)
   );

   stuff_decider #(
      .RUN_LEN (RUN_LEN)
   ) u_decide (
      .bit_tick (bit_tick),
      .stuff_en (stuff_en),
      .in_valid (in_valid),
      .in_bit   (in_bit),
      .cur_cnt  (cur_cnt),
      .cur_lvl  (cur_lvl),
      .in_ready (in_ready),
      .kind     (kind),
      .out_bit  (out_bit)
   );

   stuff_out_stage #(
      .OUT_REG    (OUT_REG),
      .IDLE_LEVEL (IDLE_LEVEL)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .emit     (emit),
      .emit_bit (out_bit),
      .tx_bit   (tx_bit),
      .tx_emit  (tx_emit)
   );

   AST_STUFF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && stuff_en && cur_cnt == CNT_W'(RUN_LEN)) |-> kind == EMIT_STUFF); // R2
   AST_STALL_ON_STUFF: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == EMIT_STUFF) |-> !in_ready); // R3
   AST_READY_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> bit_tick); // R4
   AST_NO_STUFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !stuff_en |-> kind != EMIT_STUFF); // R7

   generate
      if (OUT_REG) begin : g_out_checks
         AST_EMIT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            tx_emit |-> $past(bit_tick)); // R4
         AST_STUFF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            (kind == EMIT_STUFF) |=> tx_bit != $past(cur_lvl)); // R2
         AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (kind == EMIT_DATA) |=> (tx_emit && tx_bit == $past(in_bit))); // R7
         AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !emit |=> $stable(tx_bit)); // R4
      end
   endgenerate

endmodule

// File: tb/sim_tx_bit_stuffer.sv
`timescale 1ns/1ps
module sim_tx_bit_stuffer;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b0, stuff_en = 1'b1, frame_start = 1'b0;
   logic in_valid = 1'b0, in_bit = 1'b0;
   logic in_ready, tx_bit, tx_emit;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   bit din[$];
   bit dexp[$];
   bit dout[$];

   always #5 clk = ~clk;

   tx_bit_stuffer u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .stuff_en(stuff_en),
      .frame_start(frame_start), .in_valid(in_valid), .in_bit(in_bit),
      .in_ready(in_ready), .tx_bit(tx_bit), .tx_emit(tx_emit)
   );

   always @(negedge clk) if (rst_n && tx_emit) dout.push_back(tx_bit);

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] pack_q(input bit q[$]);
      logic [63:0] v = '0;
      foreach (q[i]) v = {v[62:0], q[i]};
      return v;
   endfunction

   task automatic load_din(input logic [63:0] v, input int n);
      din.delete();
      for (int i = n - 1; i >= 0; i--) din.push_back(v[i]);
   endtask

   task automatic load_exp(input logic [63:0] v, input int n);
      dexp.delete();
      for (int i = n - 1; i >= 0; i--) dexp.push_back(v[i]);
   endtask

   // reference: stuff after five equal levels, stuff bit opens a new run
   function automatic void model(input bit en);
      int cnt = 0;
      bit lvl = 1'b1;
      dexp.delete();
      foreach (din[i]) begin
         if (en && cnt == 5) begin
            lvl = ~lvl;
            dexp.push_back(lvl);
            cnt = 1;
         end
         dexp.push_back(din[i]);
         if (cnt != 0 && din[i] == lvl) cnt = (cnt < 5) ? cnt + 1 : 5;
         else cnt = 1;
         lvl = din[i];
      end
      if (en && cnt == 5) dexp.push_back(~lvl);
   endfunction

   task automatic send(input bit en, input string tag);
      int idx = 0;
      int flush = 0;
      int stalls = 0;
      int maxrun = 0;
      int run = 0;
      stuff_en = en;
      dout.delete();
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      while (idx < din.size() || flush < 3) begin
         bit took;
         bit_tick = 1'b1;
         in_valid = (idx < din.size());
         in_bit   = (idx < din.size()) ? din[idx] : 1'b0;
         #1;
         if (!in_ready) stalls++;
         took = in_ready && in_valid;
         @(negedge clk);
         bit_tick = 1'b0;
         in_valid = 1'b0;
         if (took) idx++;
         else if (idx >= din.size()) flush++;
         @(negedge clk);
      end
      @(negedge clk);
      check(dout.size() == dexp.size() && pack_q(dout) == pack_q(dexp),
            "R2", {tag, " stream"}, pack_q(dout), pack_q(dexp));
      check(stalls == dexp.size() - din.size(), "R3", {tag, " stalls"},
            64'(stalls), 64'(dexp.size() - din.size()));
      foreach (dout[i]) begin
         run = (i > 0 && dout[i] == dout[i-1]) ? run + 1 : 1;
         if (run > maxrun) maxrun = run;
      end
      if (en) check(maxrun <= 5, "R1", {tag, " max run"}, 64'(maxrun), 64'd5);
      if (dexp.size() > 0)
         check(tx_bit == dexp[dexp.size()-1], "R4", {tag, " hold"},
               64'(tx_bit), 64'(dexp[dexp.size()-1]));
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(tx_bit == 1'b1, "R5", "reset tx_bit", 64'(tx_bit), 64'd1);
      check(tx_emit == 1'b0, "R5", "reset tx_emit", 64'(tx_emit), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b0, "R5", "reset in_ready", 64'(in_ready), 64'd0);

      // R2: opposite data after a full run still gets a stuff bit
      load_din(64'b0111111, 7); load_exp(64'b01111101, 8); send(1'b1, "R2 0111111");
      load_din(64'b0111110, 7); load_exp(64'b01111100, 8); send(1'b1, "R2 0111110");
      // R2 and R4: a pending stuff goes out on a strobe with no data
      load_din(64'b00000, 5); load_exp(64'b000001, 6); send(1'b1, "R2 trailing");
      // R6: stuff bit is the first bit of the next run
      load_din(64'b0000011110, 10); load_exp(64'b000001111100, 12); send(1'b1, "R6 chain");
      // R7: pass-through
      load_din(64'b0000000000, 10); load_exp(64'b0000000000, 10); send(1'b0, "R7 bypass");
      // R8: frame_start between two halves clears the run
      load_din(64'b0000, 4); load_exp(64'b0000, 4); send(1'b1, "R8 first");
      load_din(64'b0000, 4); load_exp(64'b0000, 4); send(1'b1, "R8 second");

      for (int k = 0; k < 24; k++) begin
         int n = 1 + ($urandom % 40);
         bit en = (k % 6 != 5);
         bit b = 1'(($urandom % 2));
         din.delete();
         for (int j = 0; j < n; j++) begin
            if (($urandom % 4) == 0) b = ~b;
            din.push_back(b);
         end
         model(en);
         if (en)
            check(dexp.size() - n <= (n - 1) / 4, "R9", "overhead bound",
                  64'(dexp.size() - n), 64'((n - 1) / 4));
         send(en, en ? "R1 random" : "R7 random");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule